// File: doc/BRIEF.md
# ECC Error Capture Log with Severity Escalation

This block records ECC failures reported by a memory that is split into independent partitions (two by default, a lower and an upper 64-bit half). Each partition raises a one-cycle report carrying a severity (correctable single-bit or uncorrectable double-bit), the failing entry address and an 8-bit syndrome. For every partition the block holds one log slot and two sticky status flags. It drives two interrupt lines: a non-fatal line fed by single-bit flags and a fatal line fed by double-bit flags.

The log slot keeps the earliest failure. A later report of the same or lower severity does not touch it. A double-bit report is the one exception: it replaces a logged single-bit entry, so the slot always shows the worst failure seen first. Software clears a partition by writing ones to its status flags. A mask register gates the interrupt lines, and a force register lets software raise any status flag to exercise the interrupt path.

Top module: `ecc_err_log`

## Requirements
- R1: After synchronous reset, every log slot is invalid with zero address, syndrome and severity. All status flags are 0, all mask bits are 1, and both interrupt lines are 0.
- R2: A report on a partition whose slot is empty stores its address, its syndrome and its severity (log_dbe = 1 for double-bit). The slot becomes valid on the clock edge that samples the report.
- R3: While a slot is valid, a later report of equal or lower severity on that partition leaves the slot's address, syndrome and severity unchanged.
- R4: A double-bit report on a partition whose slot holds a single-bit entry overwrites the slot with the new address and syndrome and sets log_dbe.
- R5: Flag bit 2p is partition p's single-bit flag and bit 2p+1 its double-bit flag. A report sets the flag of its severity on the sampling edge, whatever the mask holds.
- R6: A write with cfg_sel = 0 clears each status flag whose write bit is 1. A write bit of 1 on either flag of a partition also empties that partition's slot and zeroes its fields. Write bits of 0 change nothing.
- R7: When a report and a clearing write hit the same partition in the same cycle, the set wins. The flag of the report's severity ends up 1 and the slot holds the new report.
- R8: A write with cfg_sel = 1 loads the mask, where a 0 bit enables the matching flag. One cycle after the flags and mask hold a value, irq_nonfatal is the OR of the unmasked single-bit flags and irq_fatal is the OR of the unmasked double-bit flags.
- R9: A write with cfg_sel = 2 sets each status flag whose write bit is 1 and leaves every log slot unchanged.
- R10: Partitions are independent. A report or clear on one partition never alters another partition's slot or flags.
- R11: A write with cfg_sel = 3 has no effect on flags, mask or log slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_vld | input | NUM_PART | Per-partition error report strobe |
| err_dbe | input | NUM_PART | Report severity, 1 = double-bit |
| err_addr | input | NUM_PART*ADDR_W | Per-partition failing entry address |
| err_syn | input | NUM_PART*SYN_W | Per-partition syndrome |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 status W1C, 1 mask, 2 force, 3 unused |
| cfg_wdata | input | 2*NUM_PART | Write data, one bit per status flag |
| stat | output | 2*NUM_PART | Sticky status flags |
| mask | output | 2*NUM_PART | Interrupt mask, 0 = enabled |
| log_valid | output | NUM_PART | Slot holds an entry |
| log_dbe | output | NUM_PART | Logged entry is double-bit |
| log_addr | output | NUM_PART*ADDR_W | Logged addresses |
| log_syn | output | NUM_PART*SYN_W | Logged syndromes |
| irq_nonfatal | output | 1 | Unmasked single-bit interrupt |
| irq_fatal | output | 1 | Unmasked double-bit interrupt |

## Verification
Directed sequences first log a single-bit error and then send a second single-bit report, which shows whether the slot holds the first entry or keeps the latest. A double-bit report follows and must escalate the slot, while a second double-bit report must not. A clearing write that lands in the same cycle as a fresh report separates set-wins from clear-wins ordering. Force, mask and unused-select writes show that flags and interrupt lines move without the log. A long random run then mixes reports on both partitions with writes to every select, and checks partition independence against a behavioural model on every cycle.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_FORCE  = 2'd2,
    SEL_SPARE  = 2'd3
  } cfg_sel_e;

  localparam int FLAGS_PER_PART = 2;
  localparam int SBE_IDX        = 0;
  localparam int DBE_IDX        = 1;

  typedef struct packed {
    logic valid;
    logic dbe;
  } slot_kind_t;

endpackage

// File: rtl/ecc_log_cfg.sv
module ecc_log_cfg
  import ecc_log_pkg::*;
#(
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [FLAG_W-1:0] cfg_wdata,
  output logic [FLAG_W-1:0] clr_bits,
  output logic [FLAG_W-1:0] frc_bits,
  output logic [FLAG_W-1:0] mask_q
);

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(cfg_sel);

  always_comb begin
    clr_bits = '0;
    frc_bits = '0;
    if (cfg_wr) begin
      case (sel)
        SEL_STATUS: clr_bits = cfg_wdata;
        SEL_FORCE:  frc_bits = cfg_wdata;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (cfg_wr && sel == SEL_MASK) begin
      mask_q <= cfg_wdata;
    end
  end

  // R8: the mask only moves on a mask write
  p_mask_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(cfg_wr && cfg_sel == 2'd1) |=> $stable(mask_q));

endmodule

// File: rtl/ecc_log_half.sv
module ecc_log_half
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int SYN_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      err_vld,
  input  logic                      err_dbe,
  input  logic [ADDR_W-1:0]         err_addr,
  input  logic [SYN_W-1:0]          err_syn,
  input  logic [FLAGS_PER_PART-1:0] clr,
  input  logic [FLAGS_PER_PART-1:0] frc,
  output logic [FLAGS_PER_PART-1:0] stat,
  output logic                      log_valid,
  output logic                      log_dbe,
  output logic [ADDR_W-1:0]         log_addr,
  output logic [SYN_W-1:0]          log_syn
);

  slot_kind_t                kind_q;
  logic                      clr_any;
  logic                      take;
  logic [FLAGS_PER_PART-1:0] set_v;

  assign clr_any = |clr;
  // empty, being cleared, or escalating single-bit to double-bit
  assign take = err_vld && (!kind_q.valid || clr_any || (!kind_q.dbe && err_dbe));

  always_comb begin
    set_v          = frc;
    set_v[SBE_IDX] = set_v[SBE_IDX] | (err_vld & ~err_dbe);
    set_v[DBE_IDX] = set_v[DBE_IDX] | (err_vld & err_dbe);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q   <= '0;
      log_addr <= '0;
      log_syn  <= '0;
    end else if (take) begin
      kind_q.valid <= 1'b1;
      kind_q.dbe   <= err_dbe;
      log_addr     <= err_addr;
      log_syn      <= err_syn;
    end else if (clr_any) begin
      kind_q   <= '0;
      log_addr <= '0;
      log_syn  <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= (stat & ~clr) | set_v;
  end

  assign log_valid = kind_q.valid;
  assign log_dbe   = kind_q.dbe;

  p_stat_sbe_r5: assert property (@(posedge clk) disable iff (rst)
    err_vld && !err_dbe |=> stat[SBE_IDX]);
  p_stat_dbe_r5: assert property (@(posedge clk) disable iff (rst)
    err_vld && err_dbe |=> stat[DBE_IDX]);
  p_first_held_r3: assert property (@(posedge clk) disable iff (rst)
    log_valid && !clr_any && (log_dbe || !err_dbe || !err_vld)
    |=> $stable(log_addr) && $stable(log_syn) && $stable(log_dbe));
  p_dbe_over_sbe_r4: assert property (@(posedge clk) disable iff (rst)
    log_valid && !log_dbe && err_vld && err_dbe
    |=> log_dbe && log_addr == $past(err_addr));
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    err_vld && clr_any |=> log_valid && log_addr == $past(err_addr));
  p_force_no_log_r9: assert property (@(posedge clk) disable iff (rst)
    (|frc) && !err_vld && !clr_any |=> $stable(log_valid) && $stable(log_addr));

endmodule

// File: rtl/ecc_log_irq.sv
module ecc_log_irq #(
  parameter int NUM_PART = 2,
  localparam int FLAG_W  = 2 * NUM_PART
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] stat,
  input  logic [FLAG_W-1:0] mask,
  output logic              irq_nonfatal,
  output logic              irq_fatal
);

  logic [NUM_PART-1:0] sbe_live;
  logic [NUM_PART-1:0] dbe_live;

  for (genvar p = 0; p < NUM_PART; p++) begin : g_live
    assign sbe_live[p] = stat[2*p]   & ~mask[2*p];
    assign dbe_live[p] = stat[2*p+1] & ~mask[2*p+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_nonfatal <= 1'b0;
      irq_fatal    <= 1'b0;
    end else begin
      irq_nonfatal <= |sbe_live;
      irq_fatal    <= |dbe_live;
    end
  end

  // R8: a fully masked flag vector never raises a line
  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (&mask) |=> !irq_nonfatal && !irq_fatal);
  p_clear_drops_r8: assert property (@(posedge clk) disable iff (rst)
    (stat == '0) |=> !irq_nonfatal && !irq_fatal);

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int NUM_PART = 2,
  parameter int ADDR_W   = 9,
  parameter int SYN_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_PART-1:0]          err_vld,
  input  logic [NUM_PART-1:0]          err_dbe,
  input  logic [NUM_PART*ADDR_W-1:0]   err_addr,
  input  logic [NUM_PART*SYN_W-1:0]    err_syn,
  input  logic                         cfg_wr,
  input  logic [1:0]                   cfg_sel,
  input  logic [2*NUM_PART-1:0]        cfg_wdata,
  output logic [2*NUM_PART-1:0]        stat,
  output logic [2*NUM_PART-1:0]        mask,
  output logic [NUM_PART-1:0]          log_valid,
  output logic [NUM_PART-1:0]          log_dbe,
  output logic [NUM_PART*ADDR_W-1:0]   log_addr,
  output logic [NUM_PART*SYN_W-1:0]    log_syn,
  output logic                         irq_nonfatal,
  output logic                         irq_fatal
);

  localparam int FLAG_W = FLAGS_PER_PART * NUM_PART;

  logic [FLAG_W-1:0] clr_bits;
  logic [FLAG_W-1:0] frc_bits;

  ecc_log_cfg #(.FLAG_W(FLAG_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .clr_bits  (clr_bits),
    .frc_bits  (frc_bits),
    .mask_q    (mask)
  );

  for (genvar p = 0; p < NUM_PART; p++) begin : g_part
    ecc_log_half #(.ADDR_W(ADDR_W), .SYN_W(SYN_W)) u_half (
      .clk       (clk),
      .rst       (rst),
      .err_vld   (err_vld[p]),
      .err_dbe   (err_dbe[p]),
      .err_addr  (err_addr[p*ADDR_W +: ADDR_W]),
      .err_syn   (err_syn[p*SYN_W +: SYN_W]),
      .clr       (clr_bits[p*FLAGS_PER_PART +: FLAGS_PER_PART]),
      .frc       (frc_bits[p*FLAGS_PER_PART +: FLAGS_PER_PART]),
      .stat      (stat[p*FLAGS_PER_PART +: FLAGS_PER_PART]),
      .log_valid (log_valid[p]),
      .log_dbe   (log_dbe[p]),
      .log_addr  (log_addr[p*ADDR_W +: ADDR_W]),
      .log_syn   (log_syn[p*SYN_W +: SYN_W])
    );
  end

  ecc_log_irq #(.NUM_PART(NUM_PART)) u_irq (
    .clk          (clk),
    .rst          (rst),
    .stat         (stat),
    .mask         (mask),
    .irq_nonfatal (irq_nonfatal),
    .irq_fatal    (irq_fatal)
  );

  // R11: a write to the unused select changes no flag, mask or slot
  p_spare_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && cfg_sel == 2'd3 && err_vld == '0
    |=> $stable(stat) && $stable(mask) && $stable(log_valid));

endmodule

// File: tb/ecc_err_log_test.sv
`timescale 1ns/1ps
module ecc_err_log_test;

  localparam int NP = 2;
  localparam int AW = 9;
  localparam int SW = 8;
  localparam int FW = 2 * NP;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NP-1:0]    err_vld = '0;
  logic [NP-1:0]    err_dbe = '0;
  logic [NP*AW-1:0] err_addr = '0;
  logic [NP*SW-1:0] err_syn = '0;
  logic             cfg_wr = 1'b0;
  logic [1:0]       cfg_sel = 2'd0;
  logic [FW-1:0]    cfg_wdata = '0;
  logic [FW-1:0]    stat, mask;
  logic [NP-1:0]    log_valid, log_dbe;
  logic [NP*AW-1:0] log_addr;
  logic [NP*SW-1:0] log_syn;
  logic             irq_nonfatal, irq_fatal;

  int tests = 0;
  int fails = 0;

  ecc_err_log #(.NUM_PART(NP), .ADDR_W(AW), .SYN_W(SW)) uut (
    .clk(clk), .rst(rst), .err_vld(err_vld), .err_dbe(err_dbe),
    .err_addr(err_addr), .err_syn(err_syn), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .stat(stat), .mask(mask),
    .log_valid(log_valid), .log_dbe(log_dbe), .log_addr(log_addr),
    .log_syn(log_syn), .irq_nonfatal(irq_nonfatal), .irq_fatal(irq_fatal)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  logic          mv [NP];
  logic          md [NP];
  logic [AW-1:0] ma [NP];
  logic [SW-1:0] ms [NP];
  logic [FW-1:0] mstat, mmask;
  logic          mirqn, mirqf;

  always @(posedge clk) begin
    logic [FW-1:0] clr, frc;
    logic          n, f;
    if (rst) begin
      for (int h = 0; h < NP; h++) begin
        mv[h] = 0; md[h] = 0; ma[h] = '0; ms[h] = '0;
      end
      mstat = '0; mmask = '1; mirqn = 0; mirqf = 0;
    end else begin
      n = 0; f = 0;
      for (int h = 0; h < NP; h++) begin
        if (mstat[2*h]   && !mmask[2*h])   n = 1;
        if (mstat[2*h+1] && !mmask[2*h+1]) f = 1;
      end
      mirqn = n; mirqf = f;
      clr = (cfg_wr && cfg_sel == 2'd0) ? cfg_wdata : '0;
      frc = (cfg_wr && cfg_sel == 2'd2) ? cfg_wdata : '0;
      mstat = (mstat & ~clr) | frc;
      for (int h = 0; h < NP; h++) begin
        logic c;
        c = clr[2*h] | clr[2*h+1];
        if (err_vld[h]) mstat[2*h + (err_dbe[h] ? 1 : 0)] = 1'b1;
        if (err_vld[h] && (!mv[h] || c || (!md[h] && err_dbe[h]))) begin
          mv[h] = 1; md[h] = err_dbe[h];
          ma[h] = err_addr[h*AW +: AW]; ms[h] = err_syn[h*SW +: SW];
        end else if (c) begin
          mv[h] = 0; md[h] = 0; ma[h] = '0; ms[h] = '0;
        end
      end
      if (cfg_wr && cfg_sel == 2'd1) mmask = cfg_wdata;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      tests++;
      for (int h = 0; h < NP; h++) begin
        if (log_valid[h] !== mv[h] || log_dbe[h] !== md[h] ||
            log_addr[h*AW +: AW] !== ma[h] || log_syn[h*SW +: SW] !== ms[h]) begin
          fails++;
          $display("FAIL R10 slot %0d actual=%b/%b/%0h/%0h expected=%b/%b/%0h/%0h", h,
                   log_valid[h], log_dbe[h], log_addr[h*AW +: AW], log_syn[h*SW +: SW],
                   mv[h], md[h], ma[h], ms[h]);
        end
      end
      if (stat !== mstat) begin
        fails++; $display("FAIL R5 stat actual=%b expected=%b", stat, mstat);
      end
      if (mask !== mmask || irq_nonfatal !== mirqn || irq_fatal !== mirqf) begin
        fails++;
        $display("FAIL R8 mask/irq actual=%b/%b/%b expected=%b/%b/%b",
                 mask, irq_nonfatal, irq_fatal, mmask, mirqn, mirqf);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [NP-1:0] v, input logic [NP-1:0] d,
                     input logic [AW-1:0] a, input logic [SW-1:0] s,
                     input logic w, input logic [1:0] sel, input logic [FW-1:0] wd);
    @(negedge clk);
    err_vld = v; err_dbe = d;
    err_addr = {NP{a}}; err_syn = {NP{s}};
    cfg_wr = w; cfg_sel = sel; cfg_wdata = wd;
  endtask

  task automatic idle();
    put('0, '0, '0, '0, 1'b0, 2'd0, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset values
    chk("R1 valid", log_valid, 0);
    chk("R1 stat", stat, 0);
    chk("R1 mask", mask, 4'hF);
    chk("R1 irq", {irq_nonfatal, irq_fatal}, 0);
    put('0, '0, '0, '0, 1'b1, 2'd1, 4'h0);          // unmask all
    put(2'b01, 2'b00, 9'd5, 8'h11, 1'b0, 2'd0, '0); // sbe on part 0
    idle();
    chk("R2 valid", log_valid, 2'b01);
    chk("R2 addr", log_addr[AW-1:0], 5);
    chk("R2 syn", log_syn[SW-1:0], 8'h11);
    chk("R5 stat", stat, 4'b0001);
    idle();
    chk("R8 nonfatal", irq_nonfatal, 1);
    put(2'b01, 2'b00, 9'd7, 8'h33, 1'b0, 2'd0, '0); idle();
    chk("R3 sbe held", log_addr[AW-1:0], 5);
    put(2'b01, 2'b01, 9'd9, 8'h22, 1'b0, 2'd0, '0); idle();
    chk("R4 addr", log_addr[AW-1:0], 9);
    chk("R4 dbe", log_dbe[0], 1);
    put(2'b01, 2'b01, 9'd3, 8'h44, 1'b0, 2'd0, '0); idle();
    chk("R3 dbe held", log_syn[SW-1:0], 8'h22);
    chk("R10 part1 untouched", {log_valid[1], stat[3:2]}, 0);
    put('0, '0, '0, '0, 1'b1, 2'd0, 4'b0001); idle();
    chk("R6 slot cleared", log_valid[0], 0);
    chk("R6 stat", stat, 4'b0010);
    put('0, '0, '0, '0, 1'b1, 2'd0, 4'b0010);
    put(2'b10, 2'b00, 9'd2, 8'h55, 1'b0, 2'd0, '0); idle();
    put(2'b10, 2'b00, 9'd1, 8'h66, 1'b1, 2'd0, 4'b0100); idle();
    chk("R7 set wins stat", stat[2], 1);
    chk("R7 new entry", log_addr[AW +: AW], 1);
    put('0, '0, '0, '0, 1'b1, 2'd2, 4'b1000); idle();
    chk("R9 forced", stat[3], 1);
    chk("R9 slot kept", {log_valid[1], log_dbe[1]}, 2'b10);
    idle();
    chk("R8 fatal", irq_fatal, 1);
    put('0, '0, '0, '0, 1'b1, 2'd1, 4'b1000); idle(); idle();
    chk("R8 masked", irq_fatal, 0);
    put('0, '0, '0, '0, 1'b1, 2'd3, 4'b1111); idle();
    chk("R11 stat", stat, 4'b1100);
    chk("R11 mask", mask, 4'b1000);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      put(r[1:0], r[3:2], r[12:4], r[20:13], (r[23:21] == 3'd0), r[25:24], r[29:26]);
    end
    idle(); idle();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule